// File: doc/BRIEF.md
# Vector element insert unit

This block takes one decoded move-to-element operation per cycle and inserts the low byte, halfword or word of a 32-bit general-purpose value into a single element of a 64-bit vector register. The unit owns a bank of 32 such registers. A write changes only the selected element. Every other bit of the target register keeps its old value.

A single 4-bit selector, formed as `{opc_hi, opc_lo}`, sets both the element width and the element position, and one of its patterns is reserved. The operation is qualified by a condition-passed input. It also needs an enable: the byte and halfword forms require vector support, while the word form needs only floating-point support. Three exception-style flags report a reserved selector, a forbidden source number and a disabled unit. All results appear exactly one clock after the operation is presented, whatever the data values are. A combinational read port exposes the register bank.

Top module: `vec_elem_insert`

## Requirements
- R1: Selector `1xxx` (bit 3 = opc_hi[1]) writes an 8-bit element at index `{opc_hi[0], opc_lo[1:0]}`, occupying bits [8*i+7:8*i].
- R2: Selector `0xx1` writes a 16-bit element at index `{opc_hi[0], opc_lo[1]}`, occupying bits [16*i+15:16*i].
- R3: Selector `0x00` writes a 32-bit element; opc_hi[0]=0 selects bits [31:0] and 1 selects bits [63:32].
- R4: Selector `0x10` raises `undef_o` and writes nothing.
- R5: The destination is `dst_sel[4:0]` (bit 4 is the high register-number bit), addressing all 32 registers.
- R6: Only the low element-width bits of `src_data` are stored; all bits outside the selected element keep their previous values.
- R7: A source number `src_sel` of 15 raises `unpred_o` and suppresses the write.
- R8: With `cond_ok` low, no write occurs and no flag is raised.
- R9: Byte and halfword forms need `vec_en`=1; the word form needs only `fp_en`=1. A missing enable raises `trap_o` and suppresses the write.
- R10: A reserved selector raises only `undef_o`; `trap_o` stays low even if the enable is missing.
- R11: Flags, `wr_en_o` and the bank update appear exactly one clock after the operation and last one cycle.
- R12: After reset every register reads zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opc_hi | input | 2 | Upper half of size/index selector |
| opc_lo | input | 2 | Lower half of size/index selector |
| dst_sel | input | 5 | Destination vector register number |
| src_sel | input | 4 | Source general-purpose register number |
| src_data | input | 32 | Source register value |
| cond_ok | input | 1 | Condition passed; qualifies the operation |
| vec_en | input | 1 | Vector support enabled |
| fp_en | input | 1 | Floating-point support enabled |
| rd_sel | input | 5 | Read-port register number |
| rd_data | output | 64 | Read-port register value |
| wr_en_o | output | 1 | A register was written this cycle |
| wr_addr_o | output | 5 | Register written |
| wr_data_o | output | 64 | Full new value of the written register |
| undef_o | output | 1 | Reserved selector pulse |
| unpred_o | output | 1 | Forbidden source number pulse |
| trap_o | output | 1 | Required enable missing pulse |

## Verification
A wrong decode of size or index shows on the read port one cycle after the operation. It appears as a changed byte outside the intended element or as an unchanged byte inside it. The full 64-bit row is compared against an independent bit-level model, so either kind of error is caught. A wrong flag or enable decision shows at the flag outputs on that same cycle. It also shows as a write that should or should not have happened, visible on the read port. A lost or stale row is carried into every later comparison of that register.

// File: rtl/vei_pkg.sv
package vei_pkg;
  localparam int VREG_W = 64;
  localparam int GPR_W  = 32;

  typedef enum logic [1:0] {ESZ_8, ESZ_16, ESZ_32, ESZ_BAD} esz_e;

  typedef struct packed {
    esz_e       size;
    logic [2:0] idx;
    logic       reserved;
    logic       need_vec;
  } dec_t;

  function automatic dec_t decode_sel(logic [1:0] hi, logic [1:0] lo);
    dec_t d;
    d = '{size: ESZ_BAD, idx: 3'd0, reserved: 1'b0, need_vec: 1'b1};
    if (hi[1]) begin
      d.size = ESZ_8;
      d.idx  = {hi[0], lo};
    end else if (lo[0]) begin
      d.size = ESZ_16;
      d.idx  = {1'b0, hi[0], lo[1]};
    end else if (!lo[1]) begin
      d.size     = ESZ_32;
      d.idx      = {2'b00, hi[0]};
      d.need_vec = 1'b0;
    end else begin
      d.reserved = 1'b1;
    end
    return d;
  endfunction

  function automatic logic [VREG_W-1:0] lane_mask(esz_e s, logic [2:0] idx);
    logic [VREG_W-1:0] m;
    case (s)
      ESZ_8:   m = {{(VREG_W-8){1'b0}},  8'hFF}        << (8 * idx);
      ESZ_16:  m = {{(VREG_W-16){1'b0}}, 16'hFFFF}     << (16 * idx[1:0]);
      ESZ_32:  m = {{(VREG_W-32){1'b0}}, 32'hFFFF_FFFF} << (32 * idx[0]);
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [VREG_W-1:0] spread(esz_e s, logic [GPR_W-1:0] v);
    logic [VREG_W-1:0] r;
    case (s)
      ESZ_8:   r = {(VREG_W/8){v[7:0]}};
      ESZ_16:  r = {(VREG_W/16){v[15:0]}};
      default: r = {(VREG_W/32){v[31:0]}};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vei_decode.sv
module vei_decode
  import vei_pkg::*;
#(
  parameter int SRC_SEL_W = 4
) (
  input  logic [1:0]           opc_hi,
  input  logic [1:0]           opc_lo,
  input  logic [SRC_SEL_W-1:0] src_sel,
  input  logic                 cond_ok,
  input  logic                 vec_en,
  input  logic                 fp_en,
  output dec_t                 dec,
  output logic                 is_undef,
  output logic                 is_unpred,
  output logic                 is_trap,
  output logic                 do_write
);
  localparam logic [SRC_SEL_W-1:0] BAD_SRC = {SRC_SEL_W{1'b1}};

  logic enable_ok;
  logic src_bad;

  always_comb begin
    dec       = decode_sel(opc_hi, opc_lo);
    enable_ok = dec.need_vec ? vec_en : fp_en;
    src_bad   = (src_sel == BAD_SRC);
    is_undef  = cond_ok & dec.reserved;
    is_unpred = cond_ok & ~dec.reserved & src_bad;
    is_trap   = cond_ok & ~dec.reserved & ~enable_ok;
    do_write  = cond_ok & ~dec.reserved & ~src_bad & enable_ok;
  end
endmodule

// File: rtl/vei_merge.sv
module vei_merge
  import vei_pkg::*;
(
  input  logic [VREG_W-1:0] old_row,
  input  dec_t              dec,
  input  logic [GPR_W-1:0]  value,
  output logic [VREG_W-1:0] new_row
);
  localparam int LANES = VREG_W / 8;

  logic [VREG_W-1:0] mask;
  logic [VREG_W-1:0] rep;

  assign mask = lane_mask(dec.size, dec.idx);
  assign rep  = spread(dec.size, value);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign new_row[g*8 +: 8] = mask[g*8] ? rep[g*8 +: 8] : old_row[g*8 +: 8];
  end
endmodule

// File: rtl/vei_regbank.sv
module vei_regbank
  import vei_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [VREG_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [VREG_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [VREG_W-1:0] rdata_b
);
  logic [VREG_W-1:0] rows [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rows[r] <= '0;
      else if (we && waddr == ADDR_W'(r))
        rows[r] <= wdata;
    end
  end

  assign rdata_a = rows[raddr_a];
  assign rdata_b = rows[raddr_b];
endmodule

// File: rtl/vec_elem_insert.sv
module vec_elem_insert
  import vei_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int SRC_SEL_W = 4,
  parameter int ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           opc_hi,
  input  logic [1:0]           opc_lo,
  input  logic [ADDR_W-1:0]    dst_sel,
  input  logic [SRC_SEL_W-1:0] src_sel,
  input  logic [GPR_W-1:0]     src_data,
  input  logic                 cond_ok,
  input  logic                 vec_en,
  input  logic                 fp_en,
  input  logic [ADDR_W-1:0]    rd_sel,
  output logic [VREG_W-1:0]    rd_data,
  output logic                 wr_en_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [VREG_W-1:0]    wr_data_o,
  output logic                 undef_o,
  output logic                 unpred_o,
  output logic                 trap_o
);
  dec_t              dec;
  logic              is_undef, is_unpred, is_trap, do_write;
  logic [VREG_W-1:0] old_row, new_row;

  vei_decode #(.SRC_SEL_W(SRC_SEL_W)) u_dec (
    .opc_hi   (opc_hi),
    .opc_lo   (opc_lo),
    .src_sel  (src_sel),
    .cond_ok  (cond_ok),
    .vec_en   (vec_en),
    .fp_en    (fp_en),
    .dec      (dec),
    .is_undef (is_undef),
    .is_unpred(is_unpred),
    .is_trap  (is_trap),
    .do_write (do_write)
  );

  vei_merge u_merge (
    .old_row(old_row),
    .dec    (dec),
    .value  (src_data),
    .new_row(new_row)
  );

  vei_regbank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (do_write),
    .waddr  (dst_sel),
    .wdata  (new_row),
    .raddr_a(dst_sel),
    .rdata_a(old_row),
    .raddr_b(rd_sel),
    .rdata_b(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      undef_o   <= 1'b0;
      unpred_o  <= 1'b0;
      trap_o    <= 1'b0;
    end else begin
      wr_en_o   <= do_write;
      wr_addr_o <= dst_sel;
      wr_data_o <= new_row;
      undef_o   <= is_undef;
      unpred_o  <= is_unpred;
      trap_o    <= is_trap;
    end
  end
endmodule

// File: rtl/vei_chk.sv
module vei_chk (
  input logic clk,
  input logic rst_n,
  input logic cond_ok,
  input logic do_write,
  input logic wr_en_o,
  input logic undef_o,
  input logic unpred_o,
  input logic trap_o
);
  // R4
  undef_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> !wr_en_o && !unpred_o);

  // R7
  unpred_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> !wr_en_o);

  // R10
  trap_not_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> !undef_o && !wr_en_o);

  // R8
  cond_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> !(wr_en_o || undef_o || unpred_o || trap_o));

  // R11
  write_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> wr_en_o);
endmodule

bind vec_elem_insert vei_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cond_ok (cond_ok),
  .do_write(do_write),
  .wr_en_o (wr_en_o),
  .undef_o (undef_o),
  .unpred_o(unpred_o),
  .trap_o  (trap_o)
);

// File: tb/vec_elem_insert_tb_top.sv
module vec_elem_insert_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  opc_hi = '0, opc_lo = '0;
  logic [4:0]  dst_sel = '0, rd_sel = '0;
  logic [3:0]  src_sel = '0;
  logic [31:0] src_data = '0;
  logic        cond_ok = 1'b0, vec_en = 1'b0, fp_en = 1'b0;
  logic [63:0] rd_data, wr_data_o;
  logic [4:0]  wr_addr_o;
  logic        wr_en_o, undef_o, unpred_o, trap_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_insert dut_i (
    .clk(clk), .rst_n(rst_n), .opc_hi(opc_hi), .opc_lo(opc_lo),
    .dst_sel(dst_sel), .src_sel(src_sel), .src_data(src_data),
    .cond_ok(cond_ok), .vec_en(vec_en), .fp_en(fp_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .undef_o(undef_o),
    .unpred_o(unpred_o), .trap_o(trap_o)
  );

  typedef struct packed {
    logic [3:0]  sel;
    logic [4:0]  dst;
    logic [3:0]  src;
    logic [31:0] data;
    logic        cond, ven, fen;
    logic        x_undef, x_unpred, x_trap;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{4'b1000, 5'd3,  4'd1,  32'hAABBCCDD, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 idx0
    '{4'b1111, 5'd3,  4'd2,  32'h00000011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 idx7
    '{4'b1010, 5'd3,  4'd0,  32'h1234565A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1/R6 idx2
    '{4'b0001, 5'd7,  4'd4,  32'h12345678, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 idx0
    '{4'b0111, 5'd7,  4'd4,  32'hFFFF9ABC, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 idx3
    '{4'b0011, 5'd7,  4'd4,  32'h0000C3C3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 idx1
    '{4'b0000, 5'd31, 4'd5,  32'hDEADBEEF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3/R9 low
    '{4'b0100, 5'd31, 4'd5,  32'hCAFEF00D, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 high
    '{4'b0010, 5'd31, 4'd5,  32'h0BADF00D, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{4'b0110, 5'd31, 4'd5,  32'h0BADF00D, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{4'b1000, 5'd3,  4'd15, 32'h00000077, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R7
    '{4'b1000, 5'd3,  4'd1,  32'h00000066, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 byte no vec
    '{4'b0000, 5'd31, 4'd1,  32'h55555555, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R9 word no fp
    '{4'b0010, 5'd31, 4'd1,  32'h55555555, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
    '{4'b1000, 5'd3,  4'd1,  32'h00000099, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8
    '{4'b0101, 5'd16, 4'd2,  32'h0000ABCD, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R5 idx2
  };

  localparam string TAG [NV] = '{"R1", "R1", "R6", "R2", "R2", "R2", "R3", "R3",
                                 "R4", "R4", "R7", "R9", "R9", "R10", "R8", "R5"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent bit-level model of one insertion
  task automatic model_write(input logic [3:0] sel, input logic [4:0] d, input logic [31:0] v);
    int esz, idx;
    if (sel[3]) begin esz = 8; idx = int'(sel[2:0]); end
    else if (sel[0]) begin esz = 16; idx = int'({sel[2], sel[1]}); end
    else begin esz = 32; idx = int'(sel[2]); end
    for (int b = 0; b < esz; b++) model[d][esz*idx + b] = v[b];
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    for (int r = 0; r < 32; r++) begin
      rd_sel = 5'(r);
      #1 check("R12", rd_data, 64'd0);
    end
    check("R12", {wr_en_o, undef_o, unpred_o, trap_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic xw;
      v = TBL[i];
      @(negedge clk);
      {opc_hi, opc_lo} = v.sel;
      dst_sel = v.dst; src_sel = v.src; src_data = v.data;
      cond_ok = v.cond; vec_en = v.ven; fp_en = v.fen;
      rd_sel = v.dst;
      xw = v.cond && !v.x_undef && !v.x_unpred && !v.x_trap;
      #1 check(TAG[i], rd_data, model[v.dst]); // not yet written (R11)
      @(negedge clk);
      cond_ok = 1'b0;
      if (xw) model_write(v.sel, v.dst, v.data);
      check(TAG[i], {63'd0, undef_o}, {63'd0, v.x_undef});
      check(TAG[i], {63'd0, unpred_o}, {63'd0, v.x_unpred});
      check(TAG[i], {63'd0, trap_o}, {63'd0, v.x_trap});
      check(TAG[i], {63'd0, wr_en_o}, {63'd0, xw});
      check(TAG[i], rd_data, model[v.dst]);
      if (xw) check(TAG[i], wr_data_o, model[v.dst]);
      @(negedge clk);
      // R11: one-cycle pulse
      check("R11", {60'd0, wr_en_o, undef_o, unpred_o, trap_o}, 64'd0);
    end

    // R6/R5: untouched registers remain as modelled
    for (int r = 0; r < 32; r++) begin
      rd_sel = 5'(r);
      #1 check("R6", rd_data, model[r]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule